// File: doc/BRIEF.md
# Barrier-Latch Pipeline with Transparent Internal Stages

This block moves data items through a run of internal storage stages that are see-through unless something forces them shut. An item is taken in by an ordinary edge-triggered input register and, at the far end, caught by an ordinary edge-triggered output register. Between the two, each internal stage simply passes its upstream value through. It closes only when it must act as a wall that keeps an item apart from the item behind it. A small controller follows every item in flight, advancing it one stage per clock. Whenever a trailing item catches up with a wall, the controller closes the stage that the item ahead is just entering. That stage captures the leading item there, and the wall that was just reached opens again.

With a gap of n cycles between two items, the leading item is captured only at stages n, 2n, 3n and so on, up to the stage count. That is floor(N/n) capture pulses, against the N that a conventionally clocked pipeline would spend. When items arrive back to back, every stage pulses, exactly as in a conventional pipeline. Any stage whose contents loop back into its own input logic can be marked by parameter: it then works as a plain register that loads every passing item and is never see-through. Each stage keeps a running count of its capture pulses, so the gating saving can be measured at the ports.

Top module: `barrier_latch_pipe`

## Requirements
- R1: After reset, out_valid is 0, out_data is 0 and every per-stage capture count is 0.
- R2: Each item whose in_valid is sampled high at a clock edge leaves on out_data, unchanged, with out_valid high for exactly one cycle, NSTG+1 clock edges later. Items leave in arrival order.
- R3: For two items n cycles apart (n ≤ NSTG), the leading item is captured exactly once at each stage whose number is a multiple of n, up to NSTG. With NSTG=3 and n=2, that is one pulse, at stage 2. The last item of a run is never captured internally.
- R4: With items on consecutive cycles (n = 1), every internal stage captures every item that has a follower.
- R5: A gap of exactly NSTG cycles gives one capture, at stage NSTG. A gap larger than NSTG gives none.
- R6: While out_valid is 0, out_data keeps the value of the last item delivered.
- R7: Once no item is in flight, every unmarked stage returns to see-through. An item sent after an idle spell is delivered with its own data and causes no capture pulse.
- R8: A stage marked in FB_MASK (bit k-1 marks stage k) is never see-through. It loads every item that passes, so its count rises by one per item, and data still leaves intact.
- R9: In a stream with mixed gaps, every stage count equals the sum, over all items, of the captures given by R3 from each item's own gap to its follower, and all data leaves intact and in order.
- R10: cap_count packs stage k's count in bits [k*CNT_W-1:(k-1)*CNT_W]. A count only ever rises, in steps of one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An item is presented this cycle |
| in_data | input | DW | Item payload |
| out_valid | output | 1 | An item leaves this cycle |
| out_data | output | DW | Payload of the leaving item, held between items |
| cap_count | output | NSTG*CNT_W | Per-stage capture pulse counts, stage 1 in the low bits |

## Verification
The bench targets the gap sizes that move the capture points:
- **Gap of one.** A controller that only closed stages on arrival of a new item, and never when a follower reached an existing wall, would show missing pulses in the upper stages.
- **Gap equal to NSTG.** This checks the boundary where a capture at the last stage either happens or is wrongly dropped.
- **Gap above NSTG.** Any capture here reveals a pulse spent for nothing.
- **Mixed-gap stream.** A capture and a reopen land on the same stage in one cycle; giving the reopen priority would overwrite a held item, so the next output would carry its follower's data.
- **Restart after a long idle.** A stage left shut would replay stale data.
- **Feedback-marked stage.** A second instance checks that this stage loads once per item without corrupting data.

// File: rtl/blp_pkg.sv
package blp_pkg;

  // State of an internal storage stage.
  typedef enum logic {
    GATE_OPEN = 1'b0,   // see-through: passes the upstream value
    GATE_SHUT = 1'b1    // opaque: presents its held value
  } gate_e;

  // Amount a capture counter steps by.
  localparam int unsigned BLP_CNT_STEP = 1;

endpackage

// File: rtl/blp_edge_reg.sv
module blp_edge_reg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  // Opaque register gated at stage level: it loads only when enabled.
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/blp_stage.sv
module blp_stage
  import blp_pkg::*;
#(
  parameter int unsigned DW       = 16,
  parameter int unsigned CNT_W    = 16,
  parameter bit          FEEDBACK = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  gate_e            gate,
  input  logic [DW-1:0]    d_in,
  output logic [DW-1:0]    view,
  output logic [CNT_W-1:0] count
);

  logic [DW-1:0] hold_q;

  // Storage is loaded only on a capture pulse.
  always_ff @(posedge clk) begin
    if (rst)       hold_q <= '0;
    else if (load) hold_q <= d_in;
  end

  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (load) count <= count + CNT_W'(BLP_CNT_STEP);
  end

  // A feedback stage always presents its held value.
  assign view = (FEEDBACK || gate == GATE_SHUT) ? hold_q : d_in;

  // R3: after a capture, the stage presents what was flowing in at that edge
  // (the controller must have shut it).
  capture_holds_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (view == $past(d_in)));

  // R10
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count != $past(count)) |-> (count == $past(count) + CNT_W'(1)));

endmodule

// File: rtl/blp_ctrl.sv
module blp_ctrl #(
  parameter int unsigned          NSTG    = 3,
  parameter logic [NSTG-1:0]      FB_MASK = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic [NSTG:1] shut,
  output logic [NSTG:1] cap,
  output logic          out_take
);

  // tok_q[p]: an item has reached position p (0 = input register).
  logic [NSTG:0] tok_q;
  logic [NSTG:1] shut_q, shut_d, cap_c, ahead;

  always_ff @(posedge clk) begin
    if (rst) tok_q <= '0;
    else     tok_q <= {tok_q[NSTG-1:0], in_valid};
  end

  // Barrier scan. A new entry (wall at position 0), or a follower about to
  // enter a shut stage, arms a capture. The nearest item at or above that wall
  // is captured in the stage it is entering at this edge.
  always_comb begin
    logic pend;
    cap_c = '0;
    pend  = in_valid;
    for (int q = 1; q <= NSTG; q++) begin
      if (tok_q[q-1] && pend) begin
        cap_c[q] = 1'b1;
        pend     = 1'b0;
      end
      if (shut_q[q] && tok_q[q-1]) pend = 1'b1;
    end
    for (int q = 1; q <= NSTG; q++) begin
      if (FB_MASK[q-1]) cap_c[q] = tok_q[q-1];
    end
  end

  // ahead[k]: some item sits at a position in k..NSTG-1.
  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int k = NSTG; k >= 1; k--) begin
      ahead[k] = acc;
      acc      = acc | tok_q[k-1];
    end
  end

  // A capture beats a reopen on the same stage.
  always_comb begin
    for (int k = 1; k <= NSTG; k++) begin
      if (FB_MASK[k-1])                                    shut_d[k] = 1'b1;
      else if (cap_c[k])                                   shut_d[k] = 1'b1;
      else if (shut_q[k] && (tok_q[k-1] || !ahead[k]))     shut_d[k] = 1'b0;
      else                                                 shut_d[k] = shut_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) shut_q <= FB_MASK;
    else     shut_q <= shut_d;
  end

  assign shut     = shut_q;
  assign cap      = cap_c;
  assign out_take = tok_q[NSTG];

  // R7
  idle_open_chk: assert property (@(posedge clk) disable iff (rst)
    !(|tok_q) |=> ((shut_q & ~FB_MASK) == '0));

  // R8
  fb_shut_chk: assert property (@(posedge clk) disable iff (rst)
    (shut_q & FB_MASK) == FB_MASK);

endmodule

// File: rtl/barrier_latch_pipe.sv
module barrier_latch_pipe
  import blp_pkg::*;
#(
  parameter int unsigned     DW      = 16,
  parameter int unsigned     NSTG    = 3,
  parameter int unsigned     CNT_W   = 16,
  parameter logic [NSTG-1:0] FB_MASK = '0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [DW-1:0]         in_data,
  output logic                  out_valid,
  output logic [DW-1:0]         out_data,
  output logic [NSTG*CNT_W-1:0] cap_count
);

  localparam int unsigned LAST = NSTG;

  logic [DW-1:0] view [0:NSTG];
  logic [NSTG:1] shut, cap;
  logic          out_take;

  blp_ctrl #(.NSTG(NSTG), .FB_MASK(FB_MASK)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .shut     (shut),
    .cap      (cap),
    .out_take (out_take)
  );

  // Input environment: holds each item until the next one overwrites it.
  blp_edge_reg #(.DW(DW)) u_in_reg (
    .clk (clk),
    .rst (rst),
    .en  (in_valid),
    .d   (in_data),
    .q   (view[0])
  );

  for (genvar k = 1; k <= NSTG; k++) begin : g_stg
    blp_stage #(
      .DW       (DW),
      .CNT_W    (CNT_W),
      .FEEDBACK (FB_MASK[k-1])
    ) u_stage (
      .clk   (clk),
      .rst   (rst),
      .load  (cap[k]),
      .gate  (shut[k] ? GATE_SHUT : GATE_OPEN),
      .d_in  (view[k-1]),
      .view  (view[k]),
      .count (cap_count[(k-1)*CNT_W +: CNT_W])
    );
  end

  // Output environment.
  blp_edge_reg #(.DW(DW)) u_out_reg (
    .clk (clk),
    .rst (rst),
    .en  (out_take),
    .d   (view[LAST]),
    .q   (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= out_take;
  end

  // R2
  take_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_take |=> out_valid);

  // R2
  valid_from_take_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(out_take));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_data));

endmodule

// File: tb/test_barrier_latch_pipe.sv
module test_barrier_latch_pipe;

  localparam int N  = 3;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int WD = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic out_valid0, out_valid1;
  logic [DW-1:0] out_data0, out_data1;
  logic [N*CW-1:0] cnt_bus0, cnt_bus1;

  always #2.5 clk = ~clk;

  barrier_latch_pipe #(.DW(DW), .NSTG(N), .CNT_W(CW)) i_barrier_latch_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid0), .out_data(out_data0), .cap_count(cnt_bus0));

  barrier_latch_pipe #(.DW(DW), .NSTG(N), .CNT_W(CW), .FB_MASK(3'b010)) i_barrier_latch_pipe_fb (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid1), .out_data(out_data1), .cap_count(cnt_bus1));

  int cyc = 0;
  int errors = 0;
  int checks = 0;
  int exp_cnt [1:N];
  int items = 0;
  int prev_cyc = 0;
  bit have_prev = 0;
  logic [DW-1:0] qd0[$], qd1[$];
  int qc0[$], qc1[$];
  logic [DW-1:0] last0 = '0, last1 = '0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int cnt0(input int q);
    return int'(cnt_bus0[(q-1)*CW +: CW]);
  endfunction

  function automatic int cnt1(input int q);
    return int'(cnt_bus1[(q-1)*CW +: CW]);
  endfunction

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Driver: called at a negedge; pushes the expectation, then waits gap cycles.
  task automatic send(input logic [DW-1:0] d, input int gap);
    if (have_prev) begin
      for (int q = cyc - prev_cyc; q <= N; q += cyc - prev_cyc) exp_cnt[q]++;
    end
    have_prev = 1;
    prev_cyc  = cyc;
    items++;
    in_valid = 1'b1;
    in_data  = d;
    qd0.push_back(d); qc0.push_back(cyc + N + 2);
    qd1.push_back(d); qc1.push_back(cyc + N + 2);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check_counts(input string tag);
    for (int q = 1; q <= N; q++)
      check(cnt0(q) == exp_cnt[q], tag, cnt0(q), exp_cnt[q]);
  endtask

  // Monitor: compares departures with the scoreboard (R2, R6, R8 data).
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid0) begin
        if (qd0.size() == 0) check(0, "R2 unexpected output", out_data0, 0);
        else begin
          check(out_data0 == qd0[0], "R2 data", out_data0, qd0[0]);
          check(cyc == qc0[0], "R2 latency", cyc, qc0[0]);
          void'(qd0.pop_front()); void'(qc0.pop_front());
        end
        last0 = out_data0;
      end else begin
        check(out_data0 == last0, "R6 hold", out_data0, last0);
      end
      if (out_valid1) begin
        if (qd1.size() == 0) check(0, "R8 unexpected output", out_data1, 0);
        else begin
          check(out_data1 == qd1[0], "R8 data", out_data1, qd1[0]);
          check(cyc == qc1[0], "R8 latency", cyc, qc1[0]);
          void'(qd1.pop_front()); void'(qc1.pop_front());
        end
        last1 = out_data1;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WD) begin
      check(0, "watchdog", cyc, WD);
      report();
    end
  end

  initial begin
    int snap [1:N];
    for (int q = 1; q <= N; q++) exp_cnt[q] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(out_valid0 == 1'b0, "R1 out_valid", out_valid0, 0);
    check(out_data0 == '0, "R1 out_data", out_data0, 0);
    for (int q = 1; q <= N; q++) check(cnt0(q) == 0, "R1 count", cnt0(q), 0);
    idle(2);

    // R3: two items two cycles apart -> one pulse at stage 2
    send(16'hA1A1, 2);
    send(16'hB2B2, 1);
    idle(N + 4);
    check(cnt0(2) == 1 && cnt0(1) == 0 && cnt0(3) == 0, "R3 single pulse",
          cnt0(1) + cnt0(2) + cnt0(3), 1);
    check_counts("R3 stage count");

    // R4: back-to-back run
    for (int i = 0; i < 5; i++) send(16'h4000 + 16'(i), 1);
    idle(N + 4);
    check_counts("R4 stage count");

    // R5: gap equal to NSTG, then gap above NSTG
    send(16'h5151, N);
    send(16'h5252, 1);
    idle(N + 4);
    check_counts("R5 gap=N");
    send(16'h5353, N + 1);
    send(16'h5454, 1);
    idle(N + 4);
    check_counts("R5 gap>N");

    // R9: mixed gaps
    begin
      int gaps [10] = '{1, 2, 1, 3, 5, 2, 1, 1, 4, 2};
      for (int i = 0; i < 10; i++) send(16'h9000 + 16'(i * 17), gaps[i]);
    end
    idle(N + 4);
    check_counts("R9 stage count");

    // R7: lone item after idle
    idle(20);
    for (int q = 1; q <= N; q++) snap[q] = cnt0(q);
    send(16'h7E7E, 1);
    idle(N + 4);
    check(last0 == 16'h7E7E, "R7 data after idle", last0, 16'h7E7E);
    for (int q = 1; q <= N; q++) check(cnt0(q) == snap[q], "R7 no pulse", cnt0(q), snap[q]);

    // R8: feedback stage loads once per item
    check(cnt1(2) == items, "R8 feedback count", cnt1(2), items);

    // R2: everything delivered
    check(qd0.size() == 0, "R2 drained", qd0.size(), 0);
    check(qd1.size() == 0, "R8 drained", qd1.size(), 0);
    report();
  end

endmodule